// File: doc/BRIEF.md
# Reset / NMI Pin Controller

This block manages one external pin that serves one of two roles at run time. After power-up it acts as an active-low reset input: once the pin has been held low for a minimum number of clock cycles, the block raises a brown-out-class reset request. Shorter low glitches are filtered out. When software sets the mode bit in the control register, the same pin becomes a non-maskable interrupt source instead. In that mode a chosen edge, rising or falling, sets a sticky flag. The flag drives the interrupt request output only while the interrupt enable bit is also set.

The raw pin passes through a two-flop synchroniser before any qualification or edge detection. The control register also holds the pad pull controls: one bit chooses the pull direction and one bit switches the pull on. Both values appear directly on output pins. Every reset request returns the register to its defaults, which are reset mode with the pull-up enabled.

Control register bits: [0] mode (0 reset, 1 NMI), [1] edge select (0 rising, 1 falling), [2] interrupt enable, [3] pull direction (1 up, 0 down), [4] pull enable, [5] NMI flag (read-only), [6] flag clear (write 1, reads 0), [7] reserved (reads 0). Default read value is 0x18.

Top module: `rstpin_ctrl`

## Requirements
- R1: After power-on reset, cfg_rdata reads 0x18, rst_req and nmi_irq are 0, and pull_up_sel and pull_en are 1.
- R2: In reset mode (bit 0 = 0), a pin low for at least QUAL_CYCLES cycles raises rst_req on the (QUAL_CYCLES+2)th rising clock edge after the pin falls. rst_req stays high while the pin is low and drops on the 3rd edge after the pin rises.
- R3: In reset mode, a low pulse shorter than QUAL_CYCLES cycles never raises rst_req.
- R4: In NMI mode (bit 0 = 1), rst_req stays 0 however long the pin is held low.
- R5: In NMI mode, the flag (bit 5) sets on the 3rd clock edge after a pin edge that matches bit 1 (0 rising, 1 falling). An edge of the opposite direction leaves the flag clear.
- R6: The flag sets whether or not the enable (bit 2) is set. nmi_irq is 1 exactly when both the flag and bit 2 are 1.
- R7: The flag stays set until a write with bit 6 = 1 clears it. If the clear and a newly detected edge fall in the same cycle, the flag stays set.
- R8: In reset mode, pin edges never set the flag.
- R9: Changing bit 1 while the pin level is steady does not set the flag.
- R10: A reset request restores the whole register to 0x18 and clears the flag.
- R11: pull_up_sel follows bit 3 and pull_en follows bit 4 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_raw | input | 1 | Unsynchronised pad input |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, including the flag |
| rst_req | output | 1 | Brown-out-class reset request |
| nmi_irq | output | 1 | Non-maskable interrupt request |
| pull_up_sel | output | 1 | Pull direction to the pad, 1 for up |
| pull_en | output | 1 | Pull resistor enable to the pad |

## Verification
A pin change passes through two synchroniser flops before it counts. As a result, the flag rises 3 edges after a matching pin edge, rst_req rises QUAL_CYCLES+2 edges after the pin falls, and rst_req drops 3 edges after the pin rises. A register write takes effect on the next edge. nmi_irq and the pad outputs follow the register without further delay. Each test drives the pin and the write port just after a falling clock edge. It then counts whole cycles to the edge where a result becomes due and samples at the following falling edge. It also samples one cycle earlier, to confirm that the result does not arrive too soon.

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl #(
  parameter int QUAL_CYCLES = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pin_raw,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       rst_req,
  output logic       nmi_irq,
  output logic       pull_up_sel,
  output logic       pull_en
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYCLES);

  logic             sync1, sync2, prev_lvl;
  logic [CNT_W-1:0] low_cnt;
  logic             mode_nmi, edge_fall, irq_en, pull_dir, pull_on, flag;
  logic [1:0]       sel_q;
  logic             reseed, hit, clr;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= pin_raw;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                 low_cnt <= '0;
    else if (mode_nmi || sync2) low_cnt <= '0;
    else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;

  assign rst_req = !mode_nmi && (low_cnt == CNT_MAX);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      {pull_on, pull_dir, irq_en, edge_fall, mode_nmi} <= 5'b11000;
    end else if (rst_req) begin
      {pull_on, pull_dir, irq_en, edge_fall, mode_nmi} <= 5'b11000;
    end else if (cfg_we) begin
      {pull_on, pull_dir, irq_en, edge_fall, mode_nmi} <= cfg_wdata[4:0];
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sel_q    <= 2'b00;
      prev_lvl <= 1'b1;
    end else begin
      sel_q    <= {mode_nmi, edge_fall};
      prev_lvl <= sync2;
    end

  assign reseed = ({mode_nmi, edge_fall} != sel_q);
  assign hit    = mode_nmi && !reseed && (prev_lvl != sync2) && (sync2 != edge_fall);
  assign clr    = cfg_we && cfg_wdata[6];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)       flag <= 1'b0;
    else if (rst_req) flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
    else if (clr)     flag <= 1'b0;

  assign nmi_irq     = flag && irq_en;
  assign pull_up_sel = pull_dir;
  assign pull_en     = pull_on;
  assign cfg_rdata   = {2'b00, flag, pull_on, pull_dir, irq_en, edge_fall, mode_nmi};
endmodule

// File: rtl/rstpin_ctrl_chk.sv
module rstpin_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       rst_req,
  input logic       nmi_irq
);
  assert_nmi_blocks_reset_R4: assert property (@(posedge clk) disable iff (!por_n)
    cfg_rdata[0] |-> !rst_req);

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!por_n)
    nmi_irq |-> (cfg_rdata[5] && cfg_rdata[2]));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_rdata[5] && !rst_req && !(cfg_we && cfg_wdata[6])) |=> cfg_rdata[5]);

  assert_no_flag_in_reset_mode_R8: assert property (@(posedge clk) disable iff (!por_n)
    (!cfg_rdata[5] && !cfg_rdata[0]) |=> !cfg_rdata[5]);

  assert_defaults_restored_R10: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> (cfg_rdata == 8'h18));
endmodule

bind rstpin_ctrl rstpin_ctrl_chk chk_i (
  .clk(clk), .por_n(por_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .rst_req(rst_req), .nmi_irq(nmi_irq)
);

// File: tb/rstpin_ctrl_tb_top.sv
module rstpin_ctrl_tb_top;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       pin_raw = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       rst_req, nmi_irq, pull_up_sel, pull_en;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rstpin_ctrl #(.QUAL_CYCLES(Q)) dut_i (
    .clk(clk), .por_n(por_n), .pin_raw(pin_raw), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rst_req(rst_req),
    .nmi_irq(nmi_irq), .pull_up_sel(pull_up_sel), .pull_en(pull_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_por();
    @(negedge clk);
    pin_raw = 1'b1;
    cfg_we  = 1'b0;
    por_n   = 1'b0;
    tick(2);
    por_n = 1'b1;
    tick(1);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1;
    cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic t_defaults_R1();
    do_por();
    chk("R1 rdata", cfg_rdata, 8'h18);
    chk("R1 rst_req", {7'd0, rst_req}, 8'd0);
    chk("R1 nmi_irq", {7'd0, nmi_irq}, 8'd0);
    chk("R1 pulls", {6'd0, pull_up_sel, pull_en}, 8'd3);
  endtask

  task automatic t_reset_pulse_R2();
    do_por();
    pin_raw = 1'b0;
    tick(Q + 1);
    chk("R2 not early", {7'd0, rst_req}, 8'd0);
    tick(1);
    chk("R2 asserted", {7'd0, rst_req}, 8'd1);
    tick(5);
    chk("R2 held", {7'd0, rst_req}, 8'd1);
    pin_raw = 1'b1;
    tick(2);
    chk("R2 still held", {7'd0, rst_req}, 8'd1);
    tick(1);
    chk("R2 released", {7'd0, rst_req}, 8'd0);
  endtask

  task automatic t_glitch_R3_R8();
    do_por();
    pin_raw = 1'b0;
    tick(Q - 1);
    pin_raw = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (rst_req) begin
        chk("R3 glitch", {7'd0, rst_req}, 8'd0);
        break;
      end
      tick(1);
    end
    chk("R3 glitch end", {7'd0, rst_req}, 8'd0);
    chk("R8 no flag", cfg_rdata, 8'h18);
  endtask

  task automatic t_nmi_blocks_R4();
    do_por();
    wr(8'h19);
    pin_raw = 1'b0;
    tick(Q + 6);
    chk("R4 no rst", {7'd0, rst_req}, 8'd0);
    pin_raw = 1'b1;
    tick(4);
  endtask

  task automatic t_rising_R5_R6_R7();
    do_por();
    wr(8'h19);
    pin_raw = 1'b0;
    tick(4);
    chk("R5 fall ignored", cfg_rdata, 8'h19);
    pin_raw = 1'b1;
    tick(2);
    chk("R5 not early", cfg_rdata, 8'h19);
    tick(1);
    chk("R5 rise sets flag", cfg_rdata, 8'h39);
    chk("R6 irq masked", {7'd0, nmi_irq}, 8'd0);
    wr(8'h1D);
    chk("R6 irq on", {7'd0, nmi_irq}, 8'd1);
    tick(3);
    chk("R7 sticky", cfg_rdata, 8'h3D);
    wr(8'h5D);
    chk("R7 cleared", cfg_rdata, 8'h1D);
    chk("R6 irq off", {7'd0, nmi_irq}, 8'd0);
  endtask

  task automatic t_falling_R5();
    do_por();
    wr(8'h1B);
    pin_raw = 1'b0;
    tick(3);
    chk("R5 fall sets flag", cfg_rdata, 8'h3B);
    wr(8'h5B);
    pin_raw = 1'b1;
    tick(4);
    chk("R5 rise ignored", cfg_rdata, 8'h1B);
  endtask

  task automatic t_collision_R7();
    do_por();
    wr(8'h19);
    pin_raw = 1'b0;
    tick(3);
    pin_raw = 1'b1;
    tick(3);
    chk("R7 setup", cfg_rdata, 8'h39);
    wr(8'h59);
    pin_raw = 1'b0;
    tick(3);
    pin_raw = 1'b1;
    tick(2);
    wr(8'h59);
    chk("R7 edge beats clear", cfg_rdata, 8'h39);
  endtask

  task automatic t_edge_sel_R9();
    do_por();
    wr(8'h19);
    wr(8'h1B);
    tick(3);
    wr(8'h19);
    tick(3);
    chk("R9 high steady", cfg_rdata, 8'h19);
    pin_raw = 1'b0;
    tick(4);
    wr(8'h1B);
    tick(3);
    wr(8'h19);
    tick(3);
    chk("R9 low steady", cfg_rdata, 8'h19);
    pin_raw = 1'b1;
    tick(4);
  endtask

  task automatic t_restore_R10_R11();
    do_por();
    wr(8'h07);
    chk("R11 pulls off", {6'd0, pull_up_sel, pull_en}, 8'd0);
    wr(8'h10);
    chk("R11 pull down on", {6'd0, pull_up_sel, pull_en}, 8'd1);
    wr(8'h19);
    pin_raw = 1'b0;
    tick(3);
    pin_raw = 1'b1;
    tick(3);
    wr(8'h24);
    chk("R10 setup", cfg_rdata, 8'h24);
    pin_raw = 1'b0;
    tick(Q + 2);
    chk("R10 rst", {7'd0, rst_req}, 8'd1);
    tick(1);
    chk("R10 defaults during", cfg_rdata, 8'h18);
    pin_raw = 1'b1;
    tick(4);
    chk("R10 defaults after", cfg_rdata, 8'h18);
    chk("R10 pulls", {6'd0, pull_up_sel, pull_en}, 8'd3);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_defaults_R1();
    t_reset_pulse_R2();
    t_glitch_R3_R8();
    t_nmi_blocks_R4();
    t_rising_R5_R6_R7();
    t_falling_R5();
    t_collision_R7();
    t_edge_sel_R9();
    t_restore_R10_R11();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule